// File: doc/BRIEF.md
# Timer-Channel UART Engine

This block is a serial receiver and transmitter whose bit timing comes from compare events against an external free-running timer, rather than from a baud-rate divider. Each direction owns one compare slot. On the receive side the slot waits for a falling edge on the synchronized line and records the timer value at that moment. It then arms a compare one and a half bit periods later, and re-arms itself by adding one bit period after every match. At each match the line level goes into a sample latch, and the latched level is shifted in as the next received bit.

The transmit side arms its slot one timer tick after a request is accepted. It then steps the slot by one bit period per match, and each match sets the next level of the outgoing line. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. All compare arithmetic wraps modulo 2^16, the same as the timer, so a frame may straddle a timer rollover. A system uses the block by feeding in the shared timer and a bit period in timer ticks. It starts transmissions with a request pulse and collects received bytes on a one-cycle valid strobe.

Top module: `cc_uart_engine`

## Requirements
- R1: During and right after reset, tx_line_o is 1, tx_busy_o, tx_done_o and rx_valid_o are 0, and rx_byte_o and rx_frame_err_o are 0.
- R2: A tx_req_i seen high at a rising edge while idle is accepted: tx_busy_o is 1 after that edge, and tx_line_o falls to 0 (start bit) after the second rising edge following it. tx_byte_i is captured at the accepting edge.
- R3: The transmitted frame is ten levels in this order: 0 (start), data bits 0 through 7, then 1 (stop). Each level is held for exactly bit_time_i clock cycles.
- R4: tx_done_o is high for exactly one cycle, beginning 10*bit_time_i cycles after the start bit began. tx_busy_o is 0 in that same cycle and 1 in the cycle before.
- R5: A tx_req_i while tx_busy_o is 1 is ignored: the frame in flight, its timing and its end stay unchanged.
- R6: While tx_busy_o is 0, tx_line_o is 1.
- R7: The receiver passes the line through a two-flop synchronizer and timestamps the start-bit falling edge. Its first compare is timestamp + bit_time_i + floor(bit_time_i/2), and each later compare adds bit_time_i. As a result, each bit is sampled floor(bit_time_i/2) cycles after that bit begins at the pin, so a level that is correct only within ±3 cycles of that point is still received.
- R8: Received bits are assembled LSB first. After the stop-bit sample, rx_byte_o carries the byte and rx_valid_o pulses high for exactly one cycle per frame.
- R9: rx_frame_err_o is 1 with the byte when the stop-bit sample is 0, and 0 when it is 1. The byte is delivered either way.
- R10: Compare values wrap modulo 2^16. Frames in both directions that span a timer rollover are sent and received correctly.
- R11: rx_byte_o and rx_frame_err_o change only in a cycle where rx_valid_o is 1, and hold their values until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_i | input | 16 | Free-running timer, one increment per clock |
| bit_time_i | input | 16 | Bit period in timer ticks |
| rx_line_i | input | 1 | Serial receive line, idles high |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe when a frame completes |
| rx_frame_err_o | output | 1 | Stop-bit sample of the last frame was 0 |
| tx_req_i | input | 1 | Transmit request |
| tx_byte_i | input | 8 | Byte to send, taken when the request is accepted |
| tx_busy_o | output | 1 | Transmit frame in progress |
| tx_done_o | output | 1 | One-cycle strobe at the end of the stop bit |
| tx_line_o | output | 1 | Serial transmit line, idles high |

## Verification
The properties assume that timer_i advances by exactly one on every clock. The compare slots match on equality, so a skipped timer value would stall a frame. They also assume that bit_time_i is at least 8 and is held constant while a frame is in flight. The stimulus drives the timer from a bench counter that is only reloaded while both directions are idle, and it changes the bit period only between frames. Receive frames are driven one level per bit_time_i cycles, with a full idle period after each stop bit, so every falling edge the receiver sees is a real start bit.

// File: rtl/cc_uart_pkg.sv
package cc_uart_pkg;
  // Receive channel operating mode: hunting for a start edge or timed sampling.
  typedef enum logic {
    RX_HUNT  = 1'b0,
    RX_TIMED = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/cc_line_sync.sv
module cc_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cc_cmp_slot.sv
module cc_cmp_slot #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_i,
  input  logic          arm_i,
  input  logic [TW-1:0] arm_val_i,
  input  logic          rearm_i,
  input  logic [TW-1:0] step_i,
  output logic          hit_o
);
  logic [TW-1:0] cmp_q;
  logic [TW-1:0] cmp_d;

  // Arming loads an absolute value; re-arming steps forward, wrapping with the timer.
  always_comb begin
    cmp_d = cmp_q;
    if (arm_i)        cmp_d = arm_val_i;
    else if (rearm_i) cmp_d = cmp_q + step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assign hit_o = (timer_i == cmp_q);
endmodule

// File: rtl/cc_rx_channel.sv
module cc_rx_channel
  import cc_uart_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] bit_time_i,
  input  logic          line_i,
  output logic [DW-1:0] byte_o,
  output logic          valid_o,
  output logic          ferr_o
);
  localparam int FRAME = DW + 1;
  localparam int CW    = $clog2(FRAME + 1);

  rx_mode_e       mode_q, mode_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [FRAME-1:0] sh_q, sh_d;
  logic           samp_q, samp_d;
  logic           take_q, take_d;
  logic           prev_q;
  logic [DW-1:0]  byte_q, byte_d;
  logic           valid_q, valid_d;
  logic           ferr_q, ferr_d;

  logic           fall;
  logic           hit;
  logic           arm;
  logic           rearm;
  logic [TW-1:0]  first_cmp;

  assign fall      = prev_q & ~line_i;
  assign arm       = (mode_q == RX_HUNT) & fall;
  assign rearm     = (mode_q == RX_TIMED) & hit;
  assign first_cmp = timer_i + bit_time_i + (bit_time_i >> 1);

  cc_cmp_slot #(.TW(TW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_i   (timer_i),
    .arm_i     (arm),
    .arm_val_i (first_cmp),
    .rearm_i   (rearm),
    .step_i    (bit_time_i),
    .hit_o     (hit)
  );

  always_comb begin
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    samp_d  = samp_q;
    take_d  = 1'b0;
    byte_d  = byte_q;
    valid_d = 1'b0;
    ferr_d  = ferr_q;
    case (mode_q)
      RX_HUNT: begin
        if (fall) begin
          mode_d = RX_TIMED;
          cnt_d  = CW'(FRAME);
        end
      end
      default: begin
        // Compare instant: latch the line; shift the latched level one cycle later.
        if (hit) begin
          samp_d = line_i;
          take_d = 1'b1;
        end
        if (take_q) begin
          sh_d  = {samp_q, sh_q[FRAME-1:1]};
          cnt_d = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            mode_d  = RX_HUNT;
            valid_d = 1'b1;
            byte_d  = sh_d[DW-1:0];
            ferr_d  = ~samp_q;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= RX_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
      samp_q  <= 1'b1;
      take_q  <= 1'b0;
      prev_q  <= 1'b1;
      byte_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      samp_q  <= samp_d;
      take_q  <= take_d;
      prev_q  <= line_i;
      byte_q  <= byte_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
endmodule

// File: rtl/cc_tx_channel.sv
module cc_tx_channel #(
  parameter int TW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] bit_time_i,
  input  logic          req_i,
  input  logic [DW-1:0] byte_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          line_o
);
  localparam int FRAME = DW + 2;
  localparam int CW    = $clog2(FRAME + 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             line_q, line_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [FRAME-1:0] sh_q, sh_d;

  logic             accept;
  logic             hit;
  logic             rearm;
  logic [TW-1:0]    first_cmp;

  assign accept    = req_i & ~busy_q;
  assign rearm     = busy_q & hit;
  assign first_cmp = timer_i + TW'(1);

  cc_cmp_slot #(.TW(TW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_i   (timer_i),
    .arm_i     (accept),
    .arm_val_i (first_cmp),
    .rearm_i   (rearm),
    .step_i    (bit_time_i),
    .hit_o     (hit)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    line_d = line_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    if (accept) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, byte_i, 1'b0};
      cnt_d  = CW'(FRAME);
    end else if (rearm) begin
      if (cnt_q == '0) begin
        // Extra compare marks the end of the stop bit.
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        line_d = sh_q[0];
        sh_d   = {1'b1, sh_q[FRAME-1:1]};
        cnt_d  = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      line_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '1;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      line_q <= line_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign line_o = line_q;
endmodule

// File: rtl/cc_uart_engine.sv
module cc_uart_engine #(
  parameter int TW        = 16,
  parameter int DW        = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] bit_time_i,
  input  logic          rx_line_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o,
  output logic          rx_frame_err_o,
  input  logic          tx_req_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          tx_busy_o,
  output logic          tx_done_o,
  output logic          tx_line_o
);
  logic rx_sync;

  cc_line_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_line_i),
    .q_o   (rx_sync)
  );

  cc_rx_channel #(.TW(TW), .DW(DW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_i    (timer_i),
    .bit_time_i (bit_time_i),
    .line_i     (rx_sync),
    .byte_o     (rx_byte_o),
    .valid_o    (rx_valid_o),
    .ferr_o     (rx_frame_err_o)
  );

  cc_tx_channel #(.TW(TW), .DW(DW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_i    (timer_i),
    .bit_time_i (bit_time_i),
    .req_i      (tx_req_i),
    .byte_i     (tx_byte_i),
    .busy_o     (tx_busy_o),
    .done_o     (tx_done_o),
    .line_o     (tx_line_o)
  );
endmodule

// File: rtl/cc_uart_engine_chk.sv
module cc_uart_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_req_i,
  input logic          tx_busy_o,
  input logic          tx_done_o,
  input logic          tx_line_o,
  input logic          rx_valid_o,
  input logic [DW-1:0] rx_byte_o,
  input logic          rx_frame_err_o
);
  p_idle_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy_o |-> tx_line_o);

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> !tx_busy_o);

  p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |=> !tx_done_o);

  p_busy_ends_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy_o) |-> tx_done_o);

  p_busy_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy_o) |-> $past(tx_req_i));

  p_request_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy_o && tx_req_i |=> tx_busy_o || tx_done_o);

  p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_byte_o) && $stable(rx_frame_err_o));
endmodule

bind cc_uart_engine cc_uart_engine_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_req_i       (tx_req_i),
  .tx_busy_o      (tx_busy_o),
  .tx_done_o      (tx_done_o),
  .tx_line_o      (tx_line_o),
  .rx_valid_o     (rx_valid_o),
  .rx_byte_o      (rx_byte_o),
  .rx_frame_err_o (rx_frame_err_o)
);

// File: tb/sim_cc_uart_engine.sv
module sim_cc_uart_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [15:0] bt;
    logic [7:0]  data;
    logic        stop;
    logic        win;
    logic        wrap;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'd16, 8'hA5, 1'b1, 1'b0, 1'b0},
    '{16'd20, 8'h3C, 1'b1, 1'b1, 1'b0},
    '{16'd9,  8'h01, 1'b1, 1'b0, 1'b0},
    '{16'd24, 8'hFE, 1'b0, 1'b0, 1'b0},
    '{16'd20, 8'h80, 1'b1, 1'b0, 1'b1},
    '{16'd33, 8'h5A, 1'b1, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer = 16'd0;
  logic        tmr_ld = 1'b0;
  logic [15:0] tmr_v = 16'd0;
  logic [15:0] bit_time = 16'd16;
  logic        rx_line = 1'b1;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic        rx_ferr;
  logic        tx_req = 1'b0;
  logic [7:0]  tx_byte = 8'h00;
  logic        tx_busy;
  logic        tx_done;
  logic        tx_line;

  int n_chk = 0;
  int n_bad = 0;
  int vcnt  = 0;
  logic [7:0] got_d = 8'h00;
  logic       got_f = 1'b0;
  logic       have_prev = 1'b0;
  logic       finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) timer <= tmr_ld ? tmr_v : timer + 16'd1;

  cc_uart_engine u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .timer_i        (timer),
    .bit_time_i     (bit_time),
    .rx_line_i      (rx_line),
    .rx_byte_o      (rx_byte),
    .rx_valid_o     (rx_valid),
    .rx_frame_err_o (rx_ferr),
    .tx_req_i       (tx_req),
    .tx_byte_i      (tx_byte),
    .tx_busy_o      (tx_busy),
    .tx_done_o      (tx_done),
    .tx_line_o      (tx_line)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      vcnt  <= vcnt + 1;
      got_d <= rx_byte;
      got_f <= rx_ferr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic load_timer(input logic [15:0] v);
    @(negedge clk); tmr_ld = 1'b1; tmr_v = v;
    @(negedge clk); tmr_ld = 1'b0;
  endtask

  function automatic logic frame_bit(input logic [7:0] d, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return d[k-1];
  endfunction

  // Send one byte and check every bit edge, the end strobe and, optionally,
  // that a request raised mid-frame is ignored (R5).
  task automatic send_tx(input logic [7:0] d, input int bt, input bit poke);
    @(negedge clk); tx_req = 1'b1; tx_byte = d;
    @(negedge clk); tx_req = 1'b0; tx_byte = ~d;
    chk(tx_busy === 1'b1 && tx_line === 1'b1, "R2 accept", {tx_busy, tx_line}, 2'b11);
    @(negedge clk);
    chk(tx_line === 1'b0, "R2 start bit latency", tx_line, 0);
    for (int n = 0; n <= 10*bt; n++) begin
      if (n > 0) @(negedge clk);
      if (poke && n == 3*bt)     begin tx_req = 1'b1; tx_byte = 8'h00; end
      if (poke && n == 3*bt + 1) tx_req = 1'b0;
      if (n < 10*bt && ((n % bt) == 0 || (n % bt) == bt-1))
        chk(tx_line === frame_bit(d, n / bt), poke ? "R5 frame unchanged" : "R3 bit level",
            tx_line, frame_bit(d, n / bt));
      if (n == 10*bt - 1)
        chk(tx_busy === 1'b1 && tx_done === 1'b0, "R4 before end", {tx_busy, tx_done}, 2'b10);
      if (n == 10*bt)
        chk(tx_busy === 1'b0 && tx_done === 1'b1 && tx_line === 1'b1, "R4 end strobe",
            {tx_busy, tx_done, tx_line}, 3'b011);
    end
    @(negedge clk);
    chk(tx_done === 1'b0 && tx_line === 1'b1, "R4 strobe one cycle", {tx_done, tx_line}, 2'b01);
  endtask

  // Drive one frame into the receiver; with win set, data bits are correct
  // only within +-3 cycles of the expected sample point (R7).
  task automatic drive_rx(input logic [7:0] d, input logic stop, input int bt, input bit win,
                          input bit wrap);
    int v0;
    if (have_prev)
      chk(rx_byte === got_d && rx_ferr === got_f, "R11 hold", rx_byte, got_d);
    v0 = vcnt;
    for (int k = 0; k < 10; k++) begin
      logic b;
      b = (k == 9) ? stop : frame_bit(d, k);
      for (int c = 0; c < bt; c++) begin
        @(negedge clk);
        if (win && k >= 1 && k <= 8 && (c < bt/2 - 3 || c > bt/2 + 3)) rx_line = ~b;
        else rx_line = b;
      end
    end
    @(negedge clk); rx_line = 1'b1;
    repeat (bt) @(negedge clk);
    chk(vcnt == v0 + 1, "R8 one valid per frame", vcnt - v0, 1);
    chk(got_d === d, win ? "R7 mid-bit sampling" : (wrap ? "R10 rx across wrap" : "R8 rx byte"),
        got_d, d);
    chk(got_f === ~stop, "R9 framing flag", got_f, ~stop);
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(tx_line === 1'b1 && tx_busy === 1'b0 && tx_done === 1'b0 && rx_valid === 1'b0
        && rx_byte === 8'h00 && rx_ferr === 1'b0, "R1 reset state",
        {tx_line, tx_busy, tx_done, rx_valid, rx_ferr}, 5'b10000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_line === 1'b1 && tx_busy === 1'b0 && rx_valid === 1'b0, "R1 after release",
        {tx_line, tx_busy, rx_valid}, 3'b100);

    for (int i = 0; i < NVEC; i++) begin
      int bt;
      bt = int'(VECS[i].bt);
      @(negedge clk); bit_time = VECS[i].bt;
      if (VECS[i].wrap) load_timer(16'hFFFF - 16'(3*bt));
      drive_rx(VECS[i].data, VECS[i].stop, bt, VECS[i].win, VECS[i].wrap);
      if (VECS[i].wrap) load_timer(16'hFFFF - 16'(3*bt));
      send_tx(VECS[i].data, bt, 1'b0);
    end

    // Directed: request while busy is ignored (R5).
    @(negedge clk); bit_time = 16'd12;
    send_tx(8'hC3, 12, 1'b1);

    // Directed: line stays idle high with no request (R6).
    begin
      bit ok;
      ok = 1'b1;
      repeat (40) begin
        @(negedge clk);
        if (tx_line !== 1'b1 || tx_busy !== 1'b0) ok = 1'b0;
      end
      chk(ok, "R6 idle high", tx_line, 1);
    end

    // Directed: recovery after a framing error, then a clean frame (R9, R11).
    @(negedge clk); bit_time = 16'd10;
    drive_rx(8'h6E, 1'b0, 10, 1'b0, 1'b0);
    drive_rx(8'h91, 1'b1, 10, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    chk(rx_byte === 8'h91 && rx_ferr === 1'b0, "R11 hold after idle", rx_byte, 8'h91);

    finish_run();
  end
endmodule